// File: doc/BRIEF.md
# Demodulated Data Output Conditioner

The conditioner sits between the raw bit stream of a radio demodulator and the data pin read by a host microcontroller. It brings the raw level into the system clock domain through a two-flop synchronizer. It then looks at that level only once per sampling tick, which is a slow strobe whose period is chosen by a 2-bit rate-range input. The same strobe is brought out as a port so that an external bit-check counter can share it.

The cleaned output can change only at a tick. Two consecutive output edges are always at least a minimum number of ticks apart. Short spikes in the input are therefore dropped, and the host never sees interrupts faster than that spacing allows. A low-time limiter counts the ticks for which the output has been low. When the count reaches the maximum it forces the output high, and the output then stays high until the input has been seen high again. An input stuck low can therefore never hold the host's data line low for more than a bounded time.

Top module: `demod_out_cond`

## Requirements
- R1: While rst_ni is low, data_o is 1 and tick_o is 0.
- R2: tick_o is a one-cycle pulse. Once a rate has been selected, its period in clock cycles is 4 for rate_sel_i=0, 8 for 1, 12 for 2 and 16 for 3.
- R3: data_o changes only on the clock edge that ends a cycle in which tick_o is 1, so every interval between output edges is a whole number of tick periods.
- R4: demod_i is synchronized by two flops and sampled only at ticks. A low pulse of one clock cycle that lies between two tick samples never reaches data_o.
- R5: Output edges are at least 2 tick periods apart. An input pulse that is sampled w consecutive ticks (low within a high stream, or high within a low stream) gives an output pulse of the same polarity lasting max(w,2) tick periods.
- R6: data_o stays low for at most 64 tick periods. An input held low longer than that gives an output low pulse of exactly 64 tick periods, followed by a forced return high.
- R7: After a forced return high, data_o stays high while the input stays low. It falls again only after the input has been sampled high at a tick and then sampled low.
- R8: When the spacing rule allows it, the level sampled at a tick appears on data_o at that tick's clock edge. A low driven right after one tick edge shows on data_o right after the next tick edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demod_i | input | 1 | Raw demodulator output, asynchronous |
| rate_sel_i | input | 2 | Rate-range select; picks the tick divider |
| tick_o | output | 1 | Sampling tick, one cycle wide, shared with the bit-check counter |
| data_o | output | 1 | Conditioned data for the host |

## Verification
For every rate range, the bench sweeps low pulses and high pulses lasting 1 to 5 ticks. A measured output width of max(w,2) tick periods shows that pulses below the spacing limit are stretched, not passed through or dropped. Every observed pair of edges is checked for whole-tick spacing and for the 2-tick minimum. A sub-tick glitch placed between samples checks that the synchronizer and tick sampling reject it. A long low of 80 ticks separates the exact 64-tick forced release from the hold that follows, and a later high-then-low input shows that the hold clears.

// File: rtl/demod_cond_pkg.sv
package demod_cond_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_FORCE  = 2'd2
  } pace_act_e;

  // bits needed to hold the values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dc_sync.sv
module dc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    if (g == 0) begin : g_first
      assign d_in = d_i;
    end else begin : g_next
      assign d_in = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RESET_VAL;
      else         stage_q[g] <= d_in;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dc_tick_gen.sv
module dc_tick_gen #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned NUM_RATES = 2 ** SEL_W,
  parameter logic [NUM_RATES*DIV_W-1:0] RATE_DIV = {16'd16, 16'd12, 16'd8, 16'd4}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] lim_tbl [NUM_RATES];
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    assign lim_tbl[g] = RATE_DIV[g*DIV_W +: DIV_W] - DIV_W'(1);
  end

  assign lim  = lim_tbl[sel_i];
  // >= so a switch to a shorter divider wraps at once
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o = tick;

endmodule

// File: rtl/dc_edge_pacer.sv
module dc_edge_pacer
  import demod_cond_pkg::*;
#(
  parameter int unsigned MIN_GAP = 2,
  parameter int unsigned MAX_LOW = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic level_i,
  output logic data_o
);

  localparam int unsigned GAP_W = cnt_w(MIN_GAP);
  localparam int unsigned LOW_W = cnt_w(MAX_LOW);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(MIN_GAP);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(MAX_LOW - 1);

  logic             data_q;
  logic             hold_q;   // set by a forced release, waits for input high
  logic [GAP_W-1:0] gap_q;    // ticks since last output edge, saturating
  logic [LOW_W-1:0] low_q;    // ticks spent low since the falling edge
  logic [GAP_W-1:0] gap_inc;
  logic             want_fall;
  logic             want_rise;
  pace_act_e        act;

  always_comb begin
    gap_inc   = (gap_q >= GAP_SAT) ? GAP_SAT : gap_q + GAP_W'(1);
    want_fall = data_q && !level_i && !hold_q;
    want_rise = !data_q && level_i;
    act       = ACT_KEEP;
    if (!data_q && (low_q == LOW_LAST))
      act = ACT_FORCE;
    else if ((gap_inc == GAP_SAT) && (want_fall || want_rise))
      act = ACT_TOGGLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b1;
      hold_q <= 1'b0;
      gap_q  <= GAP_SAT;
      low_q  <= '0;
    end else if (tick_i) begin
      unique case (act)
        ACT_FORCE: begin
          data_q <= 1'b1;
          hold_q <= !level_i;
          gap_q  <= '0;
          low_q  <= '0;
        end
        ACT_TOGGLE: begin
          data_q <= !data_q;
          hold_q <= 1'b0;
          gap_q  <= '0;
          low_q  <= '0;
        end
        default: begin
          gap_q <= gap_inc;
          low_q <= data_q ? '0 : low_q + LOW_W'(1);
          if (level_i) hold_q <= 1'b0;
        end
      endcase
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/demod_out_cond.sv
module demod_out_cond #(
  parameter int unsigned RATE_SEL_W  = 2,
  parameter int unsigned DIV_W       = 16,
  parameter logic [(2**RATE_SEL_W)*DIV_W-1:0] RATE_DIV = {16'd16, 16'd12, 16'd8, 16'd4},
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_GAP     = 2,
  parameter int unsigned MAX_LOW     = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  demod_i,
  input  logic [RATE_SEL_W-1:0] rate_sel_i,
  output logic                  tick_o,
  output logic                  data_o
);

  localparam int unsigned NUM_RATES = 2 ** RATE_SEL_W;

  logic level_sync;
  logic tick;

  dc_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (demod_i),
    .q_o   (level_sync)
  );

  dc_tick_gen #(
    .SEL_W    (RATE_SEL_W),
    .DIV_W    (DIV_W),
    .NUM_RATES(NUM_RATES),
    .RATE_DIV (RATE_DIV)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (rate_sel_i),
    .tick_o(tick)
  );

  dc_edge_pacer #(
    .MIN_GAP(MIN_GAP),
    .MAX_LOW(MAX_LOW)
  ) u_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .level_i(level_sync),
    .data_o (data_o)
  );

  assign tick_o = tick;

endmodule

// File: rtl/demod_out_cond_chk.sv
module demod_out_cond_chk #(
  parameter int unsigned MIN_GAP = 2,
  parameter int unsigned MAX_LOW = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic data_i
);

  localparam int unsigned GW = demod_cond_pkg::cnt_w(MIN_GAP);
  localparam int unsigned LW = demod_cond_pkg::cnt_w(MAX_LOW);

  logic          prev_q;
  logic [GW-1:0] gap_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      gap_q  <= GW'(MIN_GAP);
      low_q  <= '0;
    end else begin
      prev_q <= data_i;
      if (data_i != prev_q)                      gap_q <= '0;
      else if (tick_i && (gap_q < GW'(MIN_GAP))) gap_q <= gap_q + GW'(1);
      if (data_i)                                low_q <= '0;
      else if (tick_i && (low_q < LW'(MAX_LOW))) low_q <= low_q + LW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_high: assert (data_i && !tick_i);
  end

  a_r2_tick_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  a_r3_edge_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i != $past(data_i)) |-> $past(tick_i));

  a_r5_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ((gap_q + GW'(1)) < GW'(MIN_GAP))) |=> (data_i == $past(data_i)));

  a_r6_low_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_i |-> (low_q < LW'(MAX_LOW)));

  a_r6_forced_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !data_i && (low_q == LW'(MAX_LOW - 1))) |=> data_i);

endmodule

bind demod_out_cond demod_out_cond_chk #(
  .MIN_GAP(MIN_GAP),
  .MAX_LOW(MAX_LOW)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick_o),
  .data_i(data_o)
);

// File: tb/demod_out_cond_test.sv
module demod_out_cond_test;

  localparam int MIN_GAP = 2;
  localparam int MAX_LOW = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       demod = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       tick;
  logic       data;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  int  t_fall = 0;
  int  t_rise = 0;
  int  t_last = 0;
  int  lo_cycles = 0;
  int  cur_div = 4;
  bit  edge_valid = 1'b0;
  bit  done = 1'b0;
  logic prev_d = 1'b1;

  always #2 clk = ~clk;

  demod_out_cond uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .demod_i   (demod),
    .rate_sel_i(rate_sel),
    .tick_o    (tick),
    .data_o    (data)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // edge monitor: whole-tick spacing and minimum gap (R3, R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (data !== prev_d) begin
        if (edge_valid)
          check(((cyc - t_last) % cur_div == 0) && ((cyc - t_last) >= MIN_GAP * cur_div),
                "R3/R5 edge spacing", cyc - t_last, MIN_GAP * cur_div);
        if (!data) t_fall = cyc;
        else       t_rise = cyc;
        t_last     = cyc;
        edge_valid = 1'b1;
      end
      if (!data) lo_cycles++;
      prev_d = data;
    end
  end

  // returns at the negedge just after a tick edge
  task automatic tick_edge();
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_edge();
  endtask

  task automatic set_rate(input int r);
    @(negedge clk);
    rate_sel   = 2'(r);
    cur_div    = 4 * (r + 1);
    edge_valid = 1'b0;
    ticks(3);
  endtask

  task automatic low_pulse(input int w);
    demod = 1'b1;
    ticks(4);
    demod = 1'b0;
    tick_edge();
    check(data == 1'b0, "R8 fall after next tick", int'(data), 0);
    ticks(w - 1);
    demod = 1'b1;
    ticks(4);
    check(t_rise - t_fall == mx(w, MIN_GAP) * cur_div, "R5 low pulse width",
          t_rise - t_fall, mx(w, MIN_GAP) * cur_div);
  endtask

  task automatic high_pulse(input int w);
    demod = 1'b0;
    ticks(6);
    demod = 1'b1;
    ticks(w);
    demod = 1'b0;
    ticks(4);
    check(t_fall - t_rise == mx(w, MIN_GAP) * cur_div, "R5 high pulse width",
          t_fall - t_rise, mx(w, MIN_GAP) * cur_div);
    demod = 1'b1;
    ticks(4);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(data == 1'b1, "R1 data high in reset", int'(data), 1);
    check(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    rst_n = 1'b1;

    for (int r = 0; r < 4; r++) begin
      int t0;
      set_rate(r);
      for (int k = 0; k < 3; k++) begin
        tick_edge();
        t0 = cyc;
        tick_edge();
        check(cyc - t0 == cur_div, "R2 tick period", cyc - t0, cur_div);
      end
      for (int w = 1; w <= 5; w++) low_pulse(w);
      for (int w = 1; w <= 5; w++) high_pulse(w);
    end

    // R4: one-cycle glitch between samples
    set_rate(0);
    lo_cycles = 0;
    demod = 1'b0;
    @(negedge clk);
    demod = 1'b1;
    ticks(4);
    check(lo_cycles == 0, "R4 glitch rejected div4", lo_cycles, 0);
    set_rate(3);
    lo_cycles = 0;
    repeat (5) @(negedge clk);
    demod = 1'b0;
    @(negedge clk);
    demod = 1'b1;
    ticks(4);
    check(lo_cycles == 0, "R4 glitch rejected div16", lo_cycles, 0);

    // R6/R7: stuck-low input
    set_rate(0);
    demod = 1'b1;
    ticks(4);
    demod = 1'b0;
    ticks(70);
    check(t_rise - t_fall == MAX_LOW * cur_div, "R6 forced release width",
          t_rise - t_fall, MAX_LOW * cur_div);
    lo_cycles = 0;
    ticks(10);
    check(lo_cycles == 0, "R7 held high while input low", lo_cycles, 0);
    check(data == 1'b1, "R7 data high after release", int'(data), 1);
    demod = 1'b1;
    ticks(3);
    check(data == 1'b1, "R7 data high with input high", int'(data), 1);
    demod = 1'b0;
    tick_edge();
    check(data == 1'b0, "R7 falls after input high then low", int'(data), 0);
    demod = 1'b1;
    ticks(4);
    check(data == 1'b1, "R8 rises with input", int'(data), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule